// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial line. A character enters a one-deep holding buffer through an active-low load strobe. The block then moves it into a frame shifter as soon as the shifter is free. If a load arrives while a frame is still on the line, the move is held back until the frame's last stop tick. The next start bit then follows with no idle time between the two characters.

Bit timing comes from a clock enable, `tick16`, that pulses at sixteen times the bit rate. A format word selects the character length, the parity and the stop length. It is captured from dedicated inputs while a control strobe is high. Two status outputs tell the host when the buffer can take another character and when the line has fallen fully idle. After a master reset, the line-idle status stays low for a fixed settling time before the transmitter may be used.

Top module: `dbuf_uart_tx`

## Requirements
- R1: While `rst` is high and after it falls, `txd` and `buf_empty` are 1. `tx_empty` stays 0 for the first 17 rising clock edges after `rst` falls and becomes 1 after the 18th.
- R2: Each frame begins with a low start bit. Every start, data and parity bit lasts 16 `tick16` pulses.
- R3: Data goes out least significant bit first. `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, and `din` bits at or above the selected length have no effect on the line.
- R4: With `cfg_par_off` = 0, one parity bit follows the data. With `cfg_even` = 1 it makes the count of ones in data plus parity even, and with `cfg_even` = 0 it makes that count odd. With `cfg_par_off` = 1, no parity bit is sent.
- R5: The line is high during the stop time and then stays high while idle. The stop time is 16 ticks when `cfg_stop_long` = 0. When `cfg_stop_long` = 1, it is 24 ticks for 5-bit characters and 32 ticks for every other length.
- R6: `din` is copied into the buffer on each clock while `ld_n` is 0. A 0-to-1 change of `ld_n` marks the buffer full, so `buf_empty` is 0 on the following clock.
- R7: A character loaded while a frame is in flight starts its start bit on the clock right after the previous frame's final stop tick, with no idle high time in between.
- R8: `buf_empty` returns to 1 on the clock when the buffer moves into the shifter, and `tx_empty` is 0 at that moment.
- R9: `tx_empty` is 1 only when the settling time has elapsed and no frame is on the line. It rises on the clock after the last stop tick when no character is waiting.
- R10: The format register loads from the `cfg_*` inputs on every clock while `cfg_ld` is 1 and keeps the last such value after `cfg_ld` falls. Changes on `cfg_*` while `cfg_ld` is 0 do not affect frames. After reset the format is 8 data bits, no parity and the short stop time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, active high, synchronous |
| tick16 | input | 1 | Clock enable at 16x the bit rate |
| ld_n | input | 1 | Buffer load strobe, active low; rising edge requests transfer |
| din | input | DATA_W | Parallel character |
| cfg_ld | input | 1 | Format load strobe, active high |
| cfg_len | input | 2 | Length code: MIN_W + code data bits |
| cfg_par_off | input | 1 | 1 suppresses the parity bit |
| cfg_even | input | 1 | 1 even parity, 0 odd parity |
| cfg_stop_long | input | 1 | 1 selects the long stop time |
| txd | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Holding buffer can accept a character |
| tx_empty | output | 1 | No frame on the line and the settling time is over |

## Verification
The collision of interest happens when the frame shifter reaches its final stop tick in the same cycle that a waiting character has to be moved out of the buffer. In that single cycle the shifter reloads and the buffer reports empty. The bench provokes it by loading a second character while the first is still being sent. A monitor then counts the stop-time clocks of the first frame exactly and requires the line to be low in the very next sample. It also requires that the idle status never rose between the two frames.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   localparam int LEN_SEL_W = 2;

   typedef struct packed {
      logic [LEN_SEL_W-1:0] len_sel;
      logic                 par_off;
      logic                 par_even;
      logic                 stop_long;
   } tx_fmt_t;

   // power-up format: longest character, no parity, short stop
   localparam tx_fmt_t FMT_RESET = '{len_sel: '1, par_off: 1'b1, par_even: 1'b0, stop_long: 1'b0};
endpackage

// File: rtl/tx_fmt_latch.sv
module tx_fmt_latch
   import uart_tx_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    cfg_ld,
   input  tx_fmt_t fmt_in,
   output tx_fmt_t fmt_q
);
   // transparent while the strobe is high, holds the value seen last
   always_ff @(posedge clk) begin
      if (rst)         fmt_q <= FMT_RESET;
      else if (cfg_ld) fmt_q <= fmt_in;
   end
endmodule

// File: rtl/tx_rst_gate.sv
module tx_rst_gate #(
   parameter int RST_WAIT = 18
) (
   input  logic clk,
   input  logic rst,
   output logic ready
);
   localparam int CNT_W = $clog2(RST_WAIT + 1);

   logic [CNT_W-1:0] wait_cnt;

   always_ff @(posedge clk) begin
      if (rst)                             wait_cnt <= '0;
      else if (wait_cnt != CNT_W'(RST_WAIT)) wait_cnt <= wait_cnt + 1'b1;
   end

   assign ready = (wait_cnt == CNT_W'(RST_WAIT));
endmodule

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_n,
   input  logic [DATA_W-1:0] din,
   input  logic              take,
   output logic [DATA_W-1:0] buf_data,
   output logic              buf_full
);
   logic ld_q;
   logic ld_rise;

   always_ff @(posedge clk) ld_q <= ld_n;
   assign ld_rise = ld_n & ~ld_q;

   // the reset leaves the held character alone
   always_ff @(posedge clk) begin
      if (!ld_n) buf_data <= din;
   end

   // a new request outranks a transfer that happens in the same cycle
   always_ff @(posedge clk) begin
      if (rst)          buf_full <= 1'b0;
      else if (ld_rise) buf_full <= 1'b1;
      else if (take)    buf_full <= 1'b0;
   end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
   import uart_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int MIN_W  = 5,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              ready,
   input  logic              buf_full,
   input  logic [DATA_W-1:0] buf_data,
   input  tx_fmt_t           fmt,
   output logic              take,
   output logic              txd,
   output logic              idle
);
   localparam int FRM_W = DATA_W + 2;            // start + data + parity
   localparam int BC_W  = $clog2(FRM_W + 1);
   localparam int TK_W  = $clog2(2 * OVS);

   typedef enum logic [1:0] {S_IDLE, S_BITS, S_STOP} st_t;

   st_t              st;
   logic [FRM_W-1:0] sh;
   logic [BC_W-1:0]  bits_left;
   logic [TK_W-1:0]  tk;
   logic [TK_W-1:0]  stop_last;
   logic [FRM_W-1:0] frm_new;
   logic [BC_W-1:0]  nbits_new;
   logic [TK_W-1:0]  stop_new;
   logic             last_stop_tick;

   function automatic logic [FRM_W-1:0] build(input logic [DATA_W-1:0] d, input tx_fmt_t f);
      logic [FRM_W-1:0] frm;
      logic             par;
      int               len;
      len    = MIN_W + int'(f.len_sel);
      frm    = '1;
      frm[0] = 1'b0;
      par    = ~f.par_even;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < len) begin
            frm[i+1] = d[i];
            par      = par ^ d[i];
         end
      end
      if (!f.par_off) frm[len+1] = par;
      return frm;
   endfunction

   always_comb begin
      int len;
      len       = MIN_W + int'(fmt.len_sel);
      frm_new   = build(buf_data, fmt);
      nbits_new = BC_W'(1 + len + (fmt.par_off ? 0 : 1));
      if (!fmt.stop_long)  stop_new = TK_W'(OVS - 1);
      else if (len == MIN_W) stop_new = TK_W'(OVS + OVS / 2 - 1);
      else                 stop_new = TK_W'(2 * OVS - 1);
   end

   assign last_stop_tick = (st == S_STOP) && tick && (tk == '0);
   assign take           = ready && buf_full && ((st == S_IDLE) || last_stop_tick);

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= S_IDLE;
         sh        <= '1;
         bits_left <= '0;
         tk        <= '0;
         stop_last <= '0;
      end else if (take) begin
         st        <= S_BITS;
         sh        <= frm_new;
         bits_left <= nbits_new;
         tk        <= TK_W'(OVS - 1);
         stop_last <= stop_new;
      end else begin
         case (st)
            S_BITS: if (tick) begin
               if (tk != '0) begin
                  tk <= tk - 1'b1;
               end else if (bits_left == BC_W'(1)) begin
                  st <= S_STOP;
                  tk <= stop_last;
               end else begin
                  sh        <= {1'b1, sh[FRM_W-1:1]};
                  bits_left <= bits_left - 1'b1;
                  tk        <= TK_W'(OVS - 1);
               end
            end
            S_STOP: if (tick) begin
               if (tk != '0) tk <= tk - 1'b1;
               else          st <= S_IDLE;
            end
            default: ;
         endcase
      end
   end

   assign txd  = (st == S_BITS) ? sh[0] : 1'b1;
   assign idle = (st == S_IDLE);
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
   import uart_tx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MIN_W    = 5,
   parameter int OVS      = 16,
   parameter int RST_WAIT = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick16,
   input  logic              ld_n,
   input  logic [DATA_W-1:0] din,
   input  logic              cfg_ld,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_par_off,
   input  logic              cfg_even,
   input  logic              cfg_stop_long,
   output logic              txd,
   output logic              buf_empty,
   output logic              tx_empty
);
   generate
      if (MIN_W < 1 || MIN_W > DATA_W) begin : g_bad_min
         $error("MIN_W must lie in 1..DATA_W");
      end
      if (DATA_W - MIN_W >= (1 << LEN_SEL_W)) begin : g_bad_span
         $error("length range exceeds the length select field");
      end
      if (OVS < 2 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even so that a 1.5-bit stop is whole ticks");
      end
      if (RST_WAIT < 1) begin : g_bad_wait
         $error("RST_WAIT must be at least 1");
      end
   endgenerate

   tx_fmt_t           fmt_in;
   tx_fmt_t           fmt_q;
   logic              ready;
   logic              take;
   logic              buf_full;
   logic              sh_idle;
   logic [DATA_W-1:0] buf_data;

   assign fmt_in = '{len_sel: cfg_len, par_off: cfg_par_off, par_even: cfg_even, stop_long: cfg_stop_long};

   tx_fmt_latch u_fmt (
      .clk(clk), .rst(rst), .cfg_ld(cfg_ld), .fmt_in(fmt_in), .fmt_q(fmt_q)
   );

   tx_rst_gate #(.RST_WAIT(RST_WAIT)) u_gate (
      .clk(clk), .rst(rst), .ready(ready)
   );

   tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst(rst), .ld_n(ld_n), .din(din), .take(take),
      .buf_data(buf_data), .buf_full(buf_full)
   );

   tx_shifter #(.DATA_W(DATA_W), .MIN_W(MIN_W), .OVS(OVS)) u_shift (
      .clk(clk), .rst(rst), .tick(tick16), .ready(ready), .buf_full(buf_full),
      .buf_data(buf_data), .fmt(fmt_q), .take(take), .txd(txd), .idle(sh_idle)
   );

   assign buf_empty = ~buf_full;
   assign tx_empty  = sh_idle & ready;
endmodule

// File: rtl/tx_checker.sv
module tx_checker #(
   parameter int RST_WAIT = 18
) (
   input logic clk,
   input logic rst,
   input logic ld_n,
   input logic txd,
   input logic buf_empty,
   input logic tx_empty
);
   localparam int CNT_W = $clog2(RST_WAIT + 1);
   logic [CNT_W-1:0] since_rst;

   always_ff @(posedge clk) begin
      if (rst)                                since_rst <= '0;
      else if (since_rst != CNT_W'(RST_WAIT)) since_rst <= since_rst + 1'b1;
   end

   // R1: idle status held off during settling
   a_r1_settle_hold: assert property (@(posedge clk) disable iff (rst)
      (since_rst != CNT_W'(RST_WAIT)) |-> !tx_empty);

   // R9: an idle transmitter keeps the line high
   a_r9_idle_line_high: assert property (@(posedge clk) disable iff (rst)
      tx_empty |-> txd);

   // R6: a load request fills the buffer
   a_r6_load_fills: assert property (@(posedge clk) disable iff (rst)
      $rose(ld_n) |=> !buf_empty);

   // R8: emptying the buffer means a frame has started
   a_r8_move_starts_frame: assert property (@(posedge clk) disable iff (rst)
      $rose(buf_empty) |-> !tx_empty);

   // R2: a start bit only appears while busy
   a_r2_start_when_busy: assert property (@(posedge clk) disable iff (rst)
      $fell(txd) |-> !tx_empty);
endmodule

bind dbuf_uart_tx tx_checker #(.RST_WAIT(RST_WAIT)) u_chk (
   .clk(clk), .rst(rst), .ld_n(ld_n), .txd(txd),
   .buf_empty(buf_empty), .tx_empty(tx_empty)
);

// File: tb/sim_dbuf_uart_tx.sv
module sim_dbuf_uart_tx;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick16 = 1'b1;
   logic       ld_n = 1'b1;
   logic [7:0] din = '0;
   logic       cfg_ld = 1'b0;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_par_off = 1'b1;
   logic       cfg_even = 1'b0;
   logic       cfg_stop_long = 1'b0;
   logic       txd, buf_empty, tx_empty;

   always #5 clk = ~clk;

   dbuf_uart_tx u0 (
      .clk(clk), .rst(rst), .tick16(tick16), .ld_n(ld_n), .din(din),
      .cfg_ld(cfg_ld), .cfg_len(cfg_len), .cfg_par_off(cfg_par_off),
      .cfg_even(cfg_even), .cfg_stop_long(cfg_stop_long),
      .txd(txd), .buf_empty(buf_empty), .tx_empty(tx_empty)
   );

   typedef struct {
      logic [7:0] d;
      int         len;
      bit         par_en;
      bit         even;
      int         stop;
      bit         chained;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   finished = 0;

   // bench model of the latched format (R10 reset value: 8N, short stop)
   int m_len = 8;
   bit m_par = 0;
   bit m_even = 0;
   bit m_long = 0;

   task automatic chk(string req, int act, int exp, string what);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_cfg(int code, bit par_off, bit even, bit slong);
      @(negedge clk);
      cfg_len = 2'(code); cfg_par_off = par_off; cfg_even = even; cfg_stop_long = slong;
      cfg_ld = 1'b1;
      @(negedge clk);
      cfg_ld = 1'b0;
      m_len = 5 + code; m_par = !par_off; m_even = even; m_long = slong;
   endtask

   task automatic send(logic [7:0] d, bit chained, bit idle_now, string tag);
      exp_t e;
      do @(negedge clk); while (!buf_empty);
      din = d; ld_n = 1'b0;
      @(negedge clk);
      ld_n = 1'b1;
      e.d = d; e.len = m_len; e.par_en = m_par; e.even = m_even;
      e.stop = !m_long ? 16 : (m_len == 5 ? 24 : 32);
      e.chained = chained; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      chk("R6", buf_empty, 0, "buffer full after load");
      @(negedge clk);
      if (idle_now) begin
         chk("R8", buf_empty, 1, "buffer moved to shifter");
         chk("R8", tx_empty, 0, "busy after move");
      end else begin
         chk("R7", buf_empty, 0, "load held while frame in flight");
      end
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!(tx_empty && q.size() == 0));
      repeat (3) @(negedge clk);
   endtask

   // monitor: decodes the line and compares against the queue
   initial begin
      exp_t       e;
      bit         have_start;
      int         cnt;
      logic [7:0] md;
      logic       par;
      have_start = 0;
      forever begin
         if (!have_start) begin
            do @(negedge clk); while (txd !== 1'b0 || rst);
         end
         have_start = 0;
         if (q.size() == 0) begin
            chk("R2", 1, 0, "frame with nothing queued");
            continue;
         end
         e = q.pop_front();
         repeat (8) @(negedge clk);
         chk("R2", txd, 0, {"start bit ", e.tag});
         for (int i = 0; i < e.len; i++) begin
            repeat (16) @(negedge clk);
            chk("R3", txd, e.d[i], {"data bit ", e.tag});
         end
         md = e.d & 8'((1 << e.len) - 1);
         if (e.par_en) begin
            repeat (16) @(negedge clk);
            par = e.even ? ^md : ~^md;
            chk("R4", txd, par, {"parity bit ", e.tag});
         end
         repeat (8) @(negedge clk);
         cnt = 0;
         while (txd === 1'b1 && tx_empty === 1'b0 && cnt < 100) begin
            cnt++;
            @(negedge clk);
         end
         chk("R5", cnt, e.stop, {"stop clocks ", e.tag});
         if (e.chained) begin
            chk("R7", txd, 0, {"next start right after stop ", e.tag});
            have_start = (txd === 1'b0);
         end else begin
            chk("R9", tx_empty, 1, {"idle after stop ", e.tag});
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", txd, 1, "line high in reset");
      chk("R1", buf_empty, 1, "buffer empty in reset");
      chk("R1", tx_empty, 0, "not idle in reset");
      rst = 1'b0;
      repeat (17) @(negedge clk);
      chk("R1", tx_empty, 0, "still settling after 17 clocks");
      chk("R1", txd, 1, "line high while settling");
      @(negedge clk);
      chk("R1", tx_empty, 1, "idle after 18 clocks");

      send(8'hA5, 0, 1, "8N1 default");            // R10 reset format
      wait_idle();
      set_cfg(0, 0, 0, 0);
      send(8'hF3, 0, 1, "5 odd, upper bits set");   // R3 upper inputs ignored
      wait_idle();
      set_cfg(0, 0, 1, 1);
      send(8'h0B, 0, 1, "5 even 1.5 stop");
      wait_idle();
      set_cfg(1, 0, 1, 1);
      send(8'hEC, 0, 1, "6 even 2 stop");
      wait_idle();
      set_cfg(2, 0, 0, 0);
      send(8'hD5, 0, 1, "7 odd 1 stop");
      wait_idle();
      set_cfg(3, 0, 1, 1);
      send(8'h81, 0, 1, "8 even 2 stop");
      wait_idle();
      set_cfg(2, 1, 0, 0);
      send(8'h12, 1, 1, "chain first");
      send(8'h6D, 0, 0, "chain second");
      wait_idle();
      // R10: inputs move without the strobe; latched format must stay
      set_cfg(1, 0, 0, 1);
      @(negedge clk);
      cfg_len = 2'd3; cfg_par_off = 1'b1; cfg_even = 1'b1; cfg_stop_long = 1'b0;
      send(8'h3A, 0, 1, "R10 held format");
      wait_idle();
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule